// File: doc/BRIEF.md
# Event Counter Bank with Threshold Interrupts

The block holds a parameterised set of 64-bit event counters, from 1 to 32 of them. Each counter has its own event input and its own count-enable bit. Software can preload any counter through two 32-bit halves, which controls exactly when a counter reaches its threshold.

A single 64-bit threshold, written as a low word and a high word, is shared by all counters. When an increment brings a counter onto the threshold, and that counter's interrupt enable is set, the counter's pending flag is raised. The pending flags are cleared by writing ones to them. The flags, masked by their enables, are ORed into one interrupt line that goes to the chip's interrupt controller.

Register access uses a single-cycle request: strobe, write flag, word address and write data. Read data and an error flag are returned combinationally in the same cycle. A build option removes interrupt support. In that build, the enable and pending registers answer with an error.

Top module: `ecb_bank`

## Requirements
- R1: After reset, every count, count-enable bit, interrupt-enable bit, pending flag and threshold bit is zero, and `irq` is low.
- R2: Counter i advances by exactly one on each clock edge where `event_in[i]` is 1 and bit i of the count-enable register (word address 0x00) is 1; otherwise it holds its value.
- R3: A write to address 0x20+2i replaces bits 31:0 of counter i, and a write to 0x21+2i replaces bits 63:32. A write beats a simultaneous increment of the same counter. A counter at all ones wraps to zero on its next increment.
- R4: Bit i of the pending register (address 0x02) sets on the edge where an increment brings counter i equal to the threshold, and only if bit i of the interrupt-enable register (address 0x01) is 1 at that time. A preload that lands on the threshold does not set it.
- R5: Writing the pending register clears each bit written as 1. Bits written as 0 keep their value.
- R6: If a set and a clear of the same pending bit fall on the same edge, the bit ends up set.
- R7: `irq` is high exactly when some counter has both its pending bit and its interrupt-enable bit at 1. Clearing an enable lowers `irq` but leaves the pending bit in place.
- R8: The count-enable and interrupt-enable registers read back what was written. Bits at or above NUM_CTR read as zero.
- R9: The threshold is 64 bits, written at address 0x03 (bits 31:0) and address 0x04 (bits 63:32). The comparison uses all 64 bits.
- R10: An access to an unmapped address sets `acc_err`, reads zero and changes nothing. When HAS_IRQ is 0, accesses to addresses 0x01 and 0x02 also set `acc_err`, read zero and are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Word address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, valid in the same cycle as `acc_en` |
| acc_err | output | 1 | Error response for the current access |
| event_in | input | NUM_CTR | Event input, one per counter |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a threshold hit and a write-one-to-clear of the same pending bit landing on the same clock edge. The stimulus first preloads the counter to one below the threshold. It then issues the clear write in the same cycle that raises the counter's event input. Reaching the upper half of the threshold by counting would take 2^32 events, so the bench preloads both halves instead. It then checks that a hit in the low word alone, with a different high word, does not raise the flag. It also checks that a preload landing exactly on the threshold does not raise it.

// File: rtl/ecb_pkg.sv
`timescale 1ns/1ps
package ecb_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned CNT_W  = 64;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_CTR_EN   = 8'h00;
    localparam logic [ADDR_W-1:0] A_IRQ_EN   = 8'h01;
    localparam logic [ADDR_W-1:0] A_PEND     = 8'h02;
    localparam logic [ADDR_W-1:0] A_LIM_LO   = 8'h03;
    localparam logic [ADDR_W-1:0] A_LIM_HI   = 8'h04;
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 8'h20;
endpackage

// File: rtl/ecb_counter.sv
`timescale 1ns/1ps
module ecb_counter
    import ecb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             event_in,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wdata,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             hit
);
    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_st_t;

    cnt_st_t          s_d, s_q;
    logic [CNT_W-1:0] nxt_d;

    always_comb begin
        s_d   = s_q;
        nxt_d = s_q.count + CNT_W'(1);
        hit   = 1'b0;
        if (wr_lo || wr_hi) begin
            if (wr_lo) s_d.count[REG_W-1:0]     = wdata;
            if (wr_hi) s_d.count[CNT_W-1:REG_W] = wdata;
        end else if (count_en && event_in) begin
            s_d.count = nxt_d;
            hit       = (nxt_d == limit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.count;

    // R2: one step per qualified event
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count_en && event_in && !wr_lo && !wr_hi) |=> count == $past(count) + CNT_W'(1));
    // R2: no qualified event, no write, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(count_en && event_in) && !wr_lo && !wr_hi) |=> $stable(count));
    // R3: preload of the low half lands
    a_r3_preload_lo: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> count[REG_W-1:0] == $past(wdata));
    // R3: preload of the high half lands
    a_r3_preload_hi: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> count[CNT_W-1:REG_W] == $past(wdata));
endmodule

// File: rtl/ecb_irq.sv
`timescale 1ns/1ps
module ecb_irq #(
    parameter int unsigned NUM_CTR = 4,
    parameter bit          HAS_IRQ = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTR-1:0] hit,
    input  logic               wr_ien,
    input  logic               wr_pend,
    input  logic [NUM_CTR-1:0] wdata,
    output logic [NUM_CTR-1:0] ien,
    output logic [NUM_CTR-1:0] pend,
    output logic               irq
);
    if (HAS_IRQ) begin : g_irq
        typedef struct packed {
            logic [NUM_CTR-1:0] ien;
            logic [NUM_CTR-1:0] pend;
        } irq_st_t;

        irq_st_t            s_d, s_q;
        logic [NUM_CTR-1:0] set_m;
        logic [NUM_CTR-1:0] clr_m;

        always_comb begin
            s_d    = s_q;
            set_m  = hit & s_q.ien;
            clr_m  = wr_pend ? wdata : '0;
            if (wr_ien) s_d.ien = wdata;
            s_d.pend = (s_q.pend & ~clr_m) | set_m;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign ien  = s_q.ien;
        assign pend = s_q.pend;
        assign irq  = |(s_q.pend & s_q.ien);

        // R5: cleared bits drop unless a set coincides
        a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
            wr_pend |=> (pend & $past(wdata & ~set_m)) == '0);
        // R6: a set on the same edge as a clear survives
        a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (set_m != '0) |=> (pend & $past(set_m)) == $past(set_m));
        // R4: a new pending bit needs a hit on an enabled counter
        a_r4_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (pend & ~$past(pend) & ~$past(hit & ien)) == '0);
    end else begin : g_no_irq
        logic unused_irq_inputs;
        assign unused_irq_inputs = ^{clk, rst_n, hit, wr_ien, wr_pend, wdata};
        assign ien  = '0;
        assign pend = '0;
        assign irq  = 1'b0;
    end
endmodule

// File: rtl/ecb_regif.sv
`timescale 1ns/1ps
module ecb_regif
    import ecb_pkg::*;
#(
    parameter int unsigned NUM_CTR = 4,
    parameter bit          HAS_IRQ = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_en,
    input  logic                          acc_wr,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [REG_W-1:0]              acc_wdata,
    input  logic [NUM_CTR-1:0][CNT_W-1:0] counts,
    input  logic [NUM_CTR-1:0]            ien,
    input  logic [NUM_CTR-1:0]            pend,
    output logic [NUM_CTR-1:0]            ctr_en,
    output logic [CNT_W-1:0]              limit,
    output logic                          wr_ien,
    output logic                          wr_pend,
    output logic [NUM_CTR-1:0]            cnt_wr_lo,
    output logic [NUM_CTR-1:0]            cnt_wr_hi,
    output logic [REG_W-1:0]              acc_rdata,
    output logic                          acc_err
);
    typedef struct packed {
        logic [NUM_CTR-1:0] ctr_en;
        logic [CNT_W-1:0]   limit;
    } cfg_st_t;

    cfg_st_t            s_d, s_q;
    logic               mapped;
    logic               irq_reg;
    logic               wr_ok;
    logic [REG_W-1:0]   rd_raw;
    logic [NUM_CTR-1:0] sel_lo;
    logic [NUM_CTR-1:0] sel_hi;

    always_comb begin
        s_d     = s_q;
        mapped  = 1'b0;
        irq_reg = 1'b0;
        rd_raw  = '0;
        sel_lo  = '0;
        sel_hi  = '0;
        case (acc_addr)
            A_CTR_EN: begin mapped = 1'b1; rd_raw = REG_W'(s_q.ctr_en); end
            A_IRQ_EN: begin mapped = 1'b1; irq_reg = 1'b1; rd_raw = REG_W'(ien); end
            A_PEND:   begin mapped = 1'b1; irq_reg = 1'b1; rd_raw = REG_W'(pend); end
            A_LIM_LO: begin mapped = 1'b1; rd_raw = s_q.limit[REG_W-1:0]; end
            A_LIM_HI: begin mapped = 1'b1; rd_raw = s_q.limit[CNT_W-1:REG_W]; end
            default:  ;
        endcase
        for (int i = 0; i < NUM_CTR; i++) begin
            if (acc_addr == A_CNT_BASE + ADDR_W'(2 * i)) begin
                mapped    = 1'b1;
                sel_lo[i] = 1'b1;
                rd_raw    = counts[i][REG_W-1:0];
            end
            if (acc_addr == A_CNT_BASE + ADDR_W'(2 * i + 1)) begin
                mapped    = 1'b1;
                sel_hi[i] = 1'b1;
                rd_raw    = counts[i][CNT_W-1:REG_W];
            end
        end

        acc_err   = acc_en && (!mapped || (irq_reg && !HAS_IRQ));
        acc_rdata = (acc_en && !acc_err) ? rd_raw : '0;
        wr_ok     = acc_en && acc_wr && !acc_err;

        wr_ien    = wr_ok && (acc_addr == A_IRQ_EN);
        wr_pend   = wr_ok && (acc_addr == A_PEND);
        cnt_wr_lo = wr_ok ? sel_lo : '0;
        cnt_wr_hi = wr_ok ? sel_hi : '0;

        if (wr_ok && acc_addr == A_CTR_EN) s_d.ctr_en = acc_wdata[NUM_CTR-1:0];
        if (wr_ok && acc_addr == A_LIM_LO) s_d.limit[REG_W-1:0] = acc_wdata;
        if (wr_ok && acc_addr == A_LIM_HI) s_d.limit[CNT_W-1:REG_W] = acc_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctr_en = s_q.ctr_en;
    assign limit  = s_q.limit;

    // R10: the hole between the threshold and the counters is unmapped
    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_addr > A_LIM_HI && acc_addr < A_CNT_BASE) |-> (acc_err && acc_rdata == '0));
    // R8: count-enable write is visible on the next cycle
    a_r8_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_addr == A_CTR_EN) |=> ctr_en == $past(acc_wdata[NUM_CTR-1:0]));
    // R9: threshold halves land where written
    a_r9_limit_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_addr == A_LIM_HI) |=> limit[CNT_W-1:REG_W] == $past(acc_wdata));

    if (!HAS_IRQ) begin : g_chk_no_irq
        // R10: interrupt registers refuse access when support is absent
        a_r10_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_en && (acc_addr == A_IRQ_EN || acc_addr == A_PEND)) |-> (acc_err && !wr_ien && !wr_pend));
    end
endmodule

// File: rtl/ecb_bank.sv
`timescale 1ns/1ps
module ecb_bank
    import ecb_pkg::*;
#(
    parameter int unsigned NUM_CTR = 4,
    parameter bit          HAS_IRQ = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_en,
    input  logic               acc_wr,
    input  logic [7:0]         acc_addr,
    input  logic [31:0]        acc_wdata,
    output logic [31:0]        acc_rdata,
    output logic               acc_err,
    input  logic [NUM_CTR-1:0] event_in,
    output logic               irq
);
    if (NUM_CTR < 1 || NUM_CTR > 32) begin : g_bad_cfg
        $error("ecb_bank: NUM_CTR must lie in 1..32");
    end

    logic [NUM_CTR-1:0][CNT_W-1:0] counts;
    logic [NUM_CTR-1:0]            hit;
    logic [NUM_CTR-1:0]            ctr_en;
    logic [NUM_CTR-1:0]            ien;
    logic [NUM_CTR-1:0]            pend;
    logic [NUM_CTR-1:0]            cnt_wr_lo;
    logic [NUM_CTR-1:0]            cnt_wr_hi;
    logic [CNT_W-1:0]              limit;
    logic                          wr_ien;
    logic                          wr_pend;

    ecb_regif #(.NUM_CTR(NUM_CTR), .HAS_IRQ(HAS_IRQ)) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_wr    (acc_wr),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .counts    (counts),
        .ien       (ien),
        .pend      (pend),
        .ctr_en    (ctr_en),
        .limit     (limit),
        .wr_ien    (wr_ien),
        .wr_pend   (wr_pend),
        .cnt_wr_lo (cnt_wr_lo),
        .cnt_wr_hi (cnt_wr_hi),
        .acc_rdata (acc_rdata),
        .acc_err   (acc_err)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        ecb_counter u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (ctr_en[g]),
            .event_in (event_in[g]),
            .wr_lo    (cnt_wr_lo[g]),
            .wr_hi    (cnt_wr_hi[g]),
            .wdata    (acc_wdata),
            .limit    (limit),
            .count    (counts[g]),
            .hit      (hit[g])
        );
    end

    ecb_irq #(.NUM_CTR(NUM_CTR), .HAS_IRQ(HAS_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit),
        .wr_ien  (wr_ien),
        .wr_pend (wr_pend),
        .wdata   (acc_wdata[NUM_CTR-1:0]),
        .ien     (ien),
        .pend    (pend),
        .irq     (irq)
    );

    // R7: the line is only raised by an enabled pending counter
    a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend & ien) != '0);
    // R7: an enabled pending counter always drives the line
    a_r7_irq_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ien) != '0) |-> irq);
endmodule

// File: tb/tb_ecb_bank.sv
`timescale 1ns/1ps
module tb_ecb_bank;
    localparam int N = 4;

    typedef struct packed {
        logic [1:0]  op;      // 0 idle, 1 write, 2 read
        logic [7:0]  addr;
        logic [31:0] data;    // write data or expected read data
        logic [3:0]  ev;
        logic        exp_err;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0, 4'd1 },  // R1 enables zero
        '{2'd2, 8'h03, 32'h0,        4'h0, 1'b0, 1'b0, 4'd1 },  // R1 threshold zero
        '{2'd1, 8'h03, 32'h3,        4'h0, 1'b0, 1'b0, 4'd9 },
        '{2'd1, 8'h01, 32'h1,        4'h0, 1'b0, 1'b0, 4'd8 },
        '{2'd1, 8'h00, 32'h3,        4'h0, 1'b0, 1'b0, 4'd8 },
        '{2'd2, 8'h00, 32'h3,        4'h0, 1'b0, 1'b0, 4'd8 },  // R8
        '{2'd2, 8'h01, 32'h1,        4'h0, 1'b0, 1'b0, 4'd8 },  // R8
        '{2'd0, 8'h00, 32'h0,        4'h1, 1'b0, 1'b0, 4'd2 },
        '{2'd0, 8'h00, 32'h0,        4'h3, 1'b0, 1'b0, 4'd2 },
        '{2'd2, 8'h20, 32'h2,        4'h1, 1'b0, 1'b0, 4'd2 },  // R2 count 2, hit on this edge
        '{2'd2, 8'h02, 32'h1,        4'h0, 1'b0, 1'b1, 4'd4 },  // R4 pending set
        '{2'd2, 8'h20, 32'h3,        4'h0, 1'b0, 1'b1, 4'd2 },
        '{2'd2, 8'h22, 32'h1,        4'h2, 1'b0, 1'b1, 4'd2 },
        '{2'd0, 8'h00, 32'h0,        4'h2, 1'b0, 1'b1, 4'd4 },  // ctr1 hits, enable off
        '{2'd2, 8'h02, 32'h1,        4'h0, 1'b0, 1'b1, 4'd4 },  // R4 no set when disabled
        '{2'd1, 8'h02, 32'h2,        4'h0, 1'b0, 1'b1, 4'd5 },
        '{2'd2, 8'h02, 32'h1,        4'h0, 1'b0, 1'b1, 4'd5 },  // R5 zero bit untouched
        '{2'd1, 8'h01, 32'h0,        4'h0, 1'b0, 1'b1, 4'd7 },
        '{2'd2, 8'h02, 32'h1,        4'h0, 1'b0, 1'b0, 4'd7 },  // R7 masked, still pending
        '{2'd1, 8'h01, 32'h1,        4'h0, 1'b0, 1'b0, 4'd7 },
        '{2'd1, 8'h02, 32'h1,        4'h0, 1'b0, 1'b1, 4'd5 },
        '{2'd2, 8'h02, 32'h0,        4'h0, 1'b0, 1'b0, 4'd5 },  // R5 cleared
        '{2'd2, 8'h05, 32'h0,        4'h0, 1'b1, 1'b0, 4'd10},  // R10 hole
        '{2'd2, 8'h24, 32'h0,        4'h4, 1'b0, 1'b0, 4'd2 },
        '{2'd2, 8'h24, 32'h0,        4'h0, 1'b0, 1'b0, 4'd2 },  // R2 disabled holds
        '{2'd1, 8'h05, 32'h1234,     4'h0, 1'b1, 1'b0, 4'd10},  // R10 write error
        '{2'd2, 8'h60, 32'h0,        4'h0, 1'b1, 1'b0, 4'd10},  // R10 past last counter
        '{2'd1, 8'h00, 32'hFFFFFFFF, 4'h0, 1'b0, 1'b0, 4'd8 },
        '{2'd2, 8'h00, 32'h0000000F, 4'h0, 1'b0, 1'b0, 4'd8 },  // R8 upper bits zero
        '{2'd1, 8'h00, 32'h0,        4'h0, 1'b0, 1'b0, 4'd8 }
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [31:0] acc_wdata = '0;
    logic [N-1:0] event_in = '0;
    logic [31:0] acc_rdata, n_rdata;
    logic        acc_err, n_err;
    logic        irq, n_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ecb_bank #(.NUM_CTR(N), .HAS_IRQ(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_err(acc_err), .event_in(event_in), .irq(irq)
    );

    ecb_bank #(.NUM_CTR(N), .HAS_IRQ(1'b0)) dut_noirq (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(n_rdata),
        .acc_err(n_err), .event_in(event_in), .irq(n_irq)
    );

    task automatic drive(input logic [1:0] op, input logic [7:0] a,
                         input logic [31:0] d, input logic [3:0] ev);
        @(negedge clk);
        acc_en    = (op != 2'd0);
        acc_wr    = (op == 2'd1);
        acc_addr  = a;
        acc_wdata = d;
        event_in  = ev[N-1:0];
        #3;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        drive(2'd1, a, d, 4'h0);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        drive(2'd2, a, 32'h0, 4'h0);
        check(req, acc_rdata, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R1 noirq line", {31'h0, n_irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].op, VEC[i].addr, VEC[i].data, VEC[i].ev);
            n_chk++;
            if ((VEC[i].op == 2'd2 && acc_rdata !== VEC[i].data) ||
                acc_err !== VEC[i].exp_err || irq !== VEC[i].exp_irq) begin
                n_bad++;
                $display("FAIL R%0d vector %0d: got data %h err %b irq %b expected data %h err %b irq %b",
                         VEC[i].req, i, acc_rdata, acc_err, irq,
                         VEC[i].data, VEC[i].exp_err, VEC[i].exp_irq);
            end
        end

        // R3: wrap from all ones to zero
        wr(8'h00, 32'h8);
        wr(8'h26, 32'hFFFFFFFF);
        wr(8'h27, 32'hFFFFFFFF);
        drive(2'd0, 8'h00, 32'h0, 4'h8);
        rd(8'h26, 32'h0, "R3 wrap low");
        rd(8'h27, 32'h0, "R3 wrap high");
        // R3: write beats a simultaneous increment
        drive(2'd1, 8'h26, 32'h10, 4'h8);
        rd(8'h26, 32'h10, "R3 write wins");

        // R9: full 64-bit threshold compare
        wr(8'h03, 32'h5);
        wr(8'h04, 32'h1);
        wr(8'h01, 32'h8);
        wr(8'h27, 32'h0);
        wr(8'h26, 32'h4);
        drive(2'd0, 8'h00, 32'h0, 4'h8);
        rd(8'h02, 32'h0, "R9 low half only");
        // R4: preload onto the threshold does not set
        wr(8'h27, 32'h1);
        rd(8'h02, 32'h0, "R4 preload no set");
        wr(8'h26, 32'h4);
        drive(2'd0, 8'h00, 32'h0, 4'h8);
        rd(8'h02, 32'h8, "R9 full match sets");
        check("R7 irq high", {31'h0, irq}, 32'h1);

        // R6: clear and set on the same edge
        wr(8'h26, 32'h4);
        drive(2'd1, 8'h02, 32'h8, 4'h8);
        rd(8'h02, 32'h8, "R6 set wins");
        wr(8'h02, 32'h8);
        rd(8'h02, 32'h0, "R5 clear");
        check("R7 irq low", {31'h0, irq}, 32'h0);

        // R10: build without interrupt support
        drive(2'd2, 8'h01, 32'h0, 4'h0);
        check("R10 noirq enable err", {31'h0, n_err}, 32'h1);
        check("R10 noirq enable data", n_rdata, 32'h0);
        drive(2'd1, 8'h02, 32'hF, 4'h0);
        check("R10 noirq pend write err", {31'h0, n_err}, 32'h1);
        drive(2'd2, 8'h00, 32'h0, 4'h0);
        check("R10 noirq count-enable ok", {31'h0, n_err}, 32'h0);
        check("R10 noirq count-enable data", n_rdata, 32'h8);
        check("R10 noirq line", {31'h0, n_irq}, 32'h0);

        drive(2'd0, 8'h00, 32'h0, 4'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule